// File: doc/BRIEF.md
# Multicycle Multiply Writeback Interlock

This block sits beside an in-order integer pipeline with fetch, decode, execute, memory and writeback stages. It tracks a multiply whose latency is longer than one stage. When execute issues a multiply, the block starts a pipelined multiplier with a configurable latency and records the destination register. The product never goes back to the ALU bypass paths. It is written only into the register file, through the file's single write port.

Two modes exist. When overflow exceptions are disabled, later instructions may move past the multiply. A destination-register scoreboard then makes decode insert bubbles for any instruction that reads or overwrites the pending register, or that is itself a multiply. When overflow exceptions are enabled, the block holds the pipeline in the memory stage until the product is ready. The mode is sampled when the multiply issues. When the product arrives, it takes the write port, and a normal writeback that wants the port in that cycle is held for one cycle. A flush drops the pending multiply and its write.

Top module: `mul_wb_interlock`

## Requirements
- R1: After a synchronous active-low reset with idle inputs, d_bubble, m_hold, wb_hold and rf_we are all 0 and no multiply is outstanding.
- R2: A multiply accepted at clock edge k presents rf_we=1, with rf_waddr equal to its destination and rf_wdata equal to the low DATA_W bits of op_a*op_b. This happens in the cycle that begins at edge k+MUL_LAT-1, and the write is committed at edge k+MUL_LAT.
- R3: d_bubble is 1 when dec_valid is set and a nonzero dec_rs1 or dec_rs2 equals the destination of a multiply that is issuing this cycle or is outstanding. The write cycle counts as outstanding. d_bubble is 0 in the cycle after the write.
- R4: d_bubble is 1 when dec_valid and dec_we are set and a nonzero dec_rd equals the destination of an issuing or outstanding multiply.
- R5: Register 0 never causes a hazard. A multiply whose destination is register 0 never asserts a register-file write.
- R6: A decode-stage multiply (dec_is_mul=1, dec_valid=1) gets d_bubble=1 whenever another multiply is issuing or outstanding, whatever the register numbers.
- R7: A multiply issued with ovf_exc_en=0 never raises m_hold.
- R8: A multiply issued with ovf_exc_en=1 raises m_hold from the cycle after issue until the cycle before its write cycle. m_hold is 0 in the write cycle. Changes to ovf_exc_en after issue have no effect on that multiply.
- R9: In a multiply write cycle, the multiply owns the write port, and wb_hold equals wb_we. In any other cycle, rf_we, rf_waddr and rf_wdata follow wb_we, wb_rd and wb_data, and wb_hold is 0.
- R10: A flush discards a multiply issuing in the same cycle. It also clears the outstanding entry: no write for that multiply appears in the flush cycle or later, and d_bubble no longer reflects that entry from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Pipeline flush; cancels the pending multiply |
| ovf_exc_en | input | 1 | Overflow exceptions enabled; selects hold-in-memory mode at issue |
| ex_mul_issue | input | 1 | Execute stage issues a multiply this cycle |
| ex_mul_rd | input | REG_AW | Destination register of the issuing multiply |
| ex_mul_a | input | DATA_W | First multiply operand |
| ex_mul_b | input | DATA_W | Second multiply operand |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_rs1 | input | REG_AW | Decode first source register |
| dec_rs2 | input | REG_AW | Decode second source register |
| dec_we | input | 1 | Decode instruction writes a register |
| dec_rd | input | REG_AW | Decode destination register |
| dec_is_mul | input | 1 | Decode instruction is a multiply |
| wb_we | input | 1 | Normal writeback wants the write port |
| wb_rd | input | REG_AW | Normal writeback register |
| wb_data | input | DATA_W | Normal writeback value |
| d_bubble | output | 1 | Hold decode and send a bubble into execute |
| m_hold | output | 1 | Hold the pipeline with the multiply in memory stage |
| wb_hold | output | 1 | Normal writeback lost the port; hold it one cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_AW | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |

## Verification
The embedded checks assume that execute never issues a multiply while one is outstanding. The surrounding pipeline guarantees this by obeying the decode bubble that R6 requires. The bench keeps its own model of the pending multiply and drives ex_mul_issue only when that model shows no entry, including the write cycle. All other inputs are free, including flush coinciding with issue or with the write cycle. Register numbers are drawn from a small range so that source, destination and register-0 matches happen often.

// File: rtl/mwi_pkg.sv
// Shared types for the multiply writeback interlock.
package mwi_pkg;
    // Ordering mode captured when a multiply issues.
    typedef enum logic {
        MODE_PASS   = 1'b0,  // later instructions may overtake the multiply
        MODE_HOLD_M = 1'b1   // pipeline waits in memory stage for the product
    } mul_mode_e;
endpackage

// File: rtl/mwi_mul_pipe.sv
// Pipelined multiplier with a fixed latency of LAT cycles.
// Assumes at most one operation in flight (enforced upstream); a kill
// empties every stage so a cancelled product never emerges.
module mwi_mul_pipe #(
    parameter int DATA_W = 32,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              start,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              done,
    output logic [DATA_W-1:0] product
);
    logic [LAT-1:0]    vld;
    logic [DATA_W-1:0] stg [LAT];

    // First stage: capture the truncated product.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) vld[0] <= 1'b0;
        else                vld[0] <= start;
        if (start) stg[0] <= DATA_W'(op_a * op_b);
    end

    // Remaining stages: shift valid and data along.
    for (genvar i = 1; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || kill) vld[i] <= 1'b0;
            else                vld[i] <= vld[i-1];
            stg[i] <= stg[i-1];
        end
    end

    assign done    = vld[LAT-1];
    assign product = stg[LAT-1];

    // R2: a single op in flight means at most one stage is valid.
    a_r2_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld) <= 1);
endmodule

// File: rtl/mwi_scoreboard.sv
// One-entry destination scoreboard for an outstanding multiply.
// Holds the destination register and issue mode, and raises the decode
// bubble for RAW, WAW and structural (second multiply) hazards.
// Assumes issue never arrives while an entry is held.
module mwi_scoreboard
    import mwi_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              issue,
    input  logic [REG_AW-1:0] issue_rd,
    input  mul_mode_e         issue_mode,
    input  logic              retire,
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              dec_we,
    input  logic [REG_AW-1:0] dec_rd,
    input  logic              dec_is_mul,
    output logic              pend,
    output logic [REG_AW-1:0] pend_rd,
    output mul_mode_e         pend_mode,
    output logic              bubble
);
    logic issue_ok;
    logic hz_pend, hz_issue;

    // Does the decode instruction conflict with a multiply writing r?
    function automatic logic clash(input logic [REG_AW-1:0] r,
                                   input logic [REG_AW-1:0] s1,
                                   input logic [REG_AW-1:0] s2,
                                   input logic we, input logic [REG_AW-1:0] d,
                                   input logic is_mul);
        logic raw1, raw2, waw;
        raw1 = (s1 != '0) && (s1 == r);
        raw2 = (s2 != '0) && (s2 == r);
        waw  = we && (d != '0) && (d == r);
        return is_mul || raw1 || raw2 || waw;
    endfunction

    assign issue_ok = issue && !flush;

    // Entry: set on accepted issue, cleared on retire or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_rd   <= '0;
            pend_mode <= MODE_PASS;
        end else if (issue_ok) begin
            pend      <= 1'b1;
            pend_rd   <= issue_rd;
            pend_mode <= issue_mode;
        end else if (flush || retire) begin
            pend      <= 1'b0;
        end
    end

    // Hazard against the held entry and against the multiply issuing now.
    always_comb begin
        hz_pend  = pend     && clash(pend_rd,  dec_rs1, dec_rs2, dec_we, dec_rd, dec_is_mul);
        hz_issue = issue_ok && clash(issue_rd, dec_rs1, dec_rs2, dec_we, dec_rd, dec_is_mul);
        bubble   = dec_valid && (hz_pend || hz_issue);
    end

    // R6: only one multiply may be outstanding.
    a_r6_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !pend);
    // R10: a flush leaves no entry behind.
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend);
    // R6: a decode multiply is always held while an entry exists.
    a_r6_mul_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && dec_valid && dec_is_mul) |-> bubble);
endmodule

// File: rtl/mwi_wb_arb.sv
// Single write-port arbiter: a multiply product wins over a normal
// writeback, which is then told to hold for one cycle.
module mwi_wb_arb #(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mul_wr,
    input  logic [REG_AW-1:0] mul_rd,
    input  logic [DATA_W-1:0] mul_data,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic [DATA_W-1:0] wb_data,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              wb_hold
);
    // Port select: multiply first, then normal writeback.
    always_comb begin
        rf_we    = mul_wr || wb_we;
        rf_waddr = mul_wr ? mul_rd   : wb_rd;
        rf_wdata = mul_wr ? mul_data : wb_data;
        wb_hold  = mul_wr && wb_we;
    end

    // R9: a held writeback means the port carries the product.
    a_r9_port_to_mul: assert property (@(posedge clk) disable iff (!rst_n)
        wb_hold |-> (rf_we && rf_waddr == mul_rd && rf_wdata == mul_data));
endmodule

// File: rtl/mul_wb_interlock.sv
// Multicycle multiply writeback interlock (top).
// Issues multiplies into a LAT-cycle multiplier, tracks one outstanding
// destination, raises decode bubbles or a memory-stage hold depending on
// the mode latched at issue, and shares the register-file write port.
// The product is never forwarded to the ALU; it goes to the register file.
module mul_wb_interlock
    import mwi_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 32,
    parameter int MUL_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ovf_exc_en,
    input  logic              ex_mul_issue,
    input  logic [REG_AW-1:0] ex_mul_rd,
    input  logic [DATA_W-1:0] ex_mul_a,
    input  logic [DATA_W-1:0] ex_mul_b,
    input  logic              dec_valid,
    input  logic [REG_AW-1:0] dec_rs1,
    input  logic [REG_AW-1:0] dec_rs2,
    input  logic              dec_we,
    input  logic [REG_AW-1:0] dec_rd,
    input  logic              dec_is_mul,
    input  logic              wb_we,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic [DATA_W-1:0] wb_data,
    output logic              d_bubble,
    output logic              m_hold,
    output logic              wb_hold,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);
    logic              mul_done;
    logic [DATA_W-1:0] mul_prod;
    logic              sb_pend;
    logic [REG_AW-1:0] sb_rd;
    mul_mode_e         sb_mode;
    mul_mode_e         issue_mode;
    logic              mul_wr;

    assign issue_mode = ovf_exc_en ? MODE_HOLD_M : MODE_PASS;

    mwi_mul_pipe #(.DATA_W(DATA_W), .LAT(MUL_LAT)) u_mul (
        .clk(clk), .rst_n(rst_n), .kill(flush),
        .start(ex_mul_issue && !flush),
        .op_a(ex_mul_a), .op_b(ex_mul_b),
        .done(mul_done), .product(mul_prod)
    );

    mwi_scoreboard #(.REG_AW(REG_AW)) u_sb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .issue(ex_mul_issue), .issue_rd(ex_mul_rd), .issue_mode(issue_mode),
        .retire(mul_done),
        .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_we(dec_we), .dec_rd(dec_rd), .dec_is_mul(dec_is_mul),
        .pend(sb_pend), .pend_rd(sb_rd), .pend_mode(sb_mode),
        .bubble(d_bubble)
    );

    // Product write request: not to r0 and not in a flush cycle.
    always_comb begin
        mul_wr = mul_done && (sb_rd != '0) && !flush;
        m_hold = sb_pend && (sb_mode == MODE_HOLD_M) && !mul_done;
    end

    mwi_wb_arb #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .mul_wr(mul_wr), .mul_rd(sb_rd), .mul_data(mul_prod),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .wb_hold(wb_hold)
    );

    // R2: a product only emerges for a recorded multiply.
    a_r2_done_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> sb_pend);
    // R7: pass-mode multiplies never hold the memory stage.
    a_r7_pass_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_pend && sb_mode == MODE_PASS) |-> !m_hold);
    // R5: the multiply never writes register 0.
    a_r5_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
        mul_wr |-> (rf_waddr != '0));
    // R8: the held multiply keeps its destination while holding.
    a_r8_hold_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        m_hold |=> $stable(sb_rd));
endmodule

// File: tb/tb_mul_wb_interlock.sv
module tb_mul_wb_interlock;
    localparam int AW  = 5;
    localparam int DW  = 32;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic flush, ovf_exc_en, ex_mul_issue;
    logic [AW-1:0] ex_mul_rd, dec_rs1, dec_rs2, dec_rd, wb_rd;
    logic [DW-1:0] ex_mul_a, ex_mul_b, wb_data;
    logic dec_valid, dec_we, dec_is_mul, wb_we;
    logic d_bubble, m_hold, wb_hold, rf_we;
    logic [AW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;

    int total = 0;
    int bad   = 0;

    // Reference model of the outstanding multiply.
    logic          m_pend;
    int            m_age;
    logic [AW-1:0] m_rd;
    logic          m_mode;
    logic [DW-1:0] m_prod;

    always #10 clk = ~clk;

    mul_wb_interlock #(.REG_AW(AW), .DATA_W(DW), .MUL_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ovf_exc_en(ovf_exc_en),
        .ex_mul_issue(ex_mul_issue), .ex_mul_rd(ex_mul_rd),
        .ex_mul_a(ex_mul_a), .ex_mul_b(ex_mul_b),
        .dec_valid(dec_valid), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .dec_we(dec_we), .dec_rd(dec_rd), .dec_is_mul(dec_is_mul),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
        .d_bubble(d_bubble), .m_hold(m_hold), .wb_hold(wb_hold),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic hz(input logic v, input logic [AW-1:0] r);
        logic m;
        m = dec_is_mul || (dec_rs1 != 0 && dec_rs1 == r) ||
            (dec_rs2 != 0 && dec_rs2 == r) ||
            (dec_we && dec_rd != 0 && dec_rd == r);
        return v && m;
    endfunction

    task automatic idle();
        flush = 0; ovf_exc_en = 0; ex_mul_issue = 0; ex_mul_rd = 0;
        ex_mul_a = 0; ex_mul_b = 0; dec_valid = 0; dec_rs1 = 0; dec_rs2 = 0;
        dec_we = 0; dec_rd = 0; dec_is_mul = 0; wb_we = 0; wb_rd = 0; wb_data = 0;
    endtask

    // Check all outputs against the model for the current inputs, then
    // advance the model across the coming edge and move to the next negedge.
    task automatic run_cycle();
        logic mdone, mw, e_we, e_bub, e_hold, iss;
        #2;
        mdone  = m_pend && m_age == LAT;
        mw     = mdone && m_rd != 0 && !flush;
        e_we   = mw || wb_we;
        iss    = ex_mul_issue && !flush;
        e_hold = m_pend && m_mode && !mdone;
        e_bub  = dec_valid && (hz(m_pend, m_rd) || hz(iss, ex_mul_rd));
        chk("R2 R5 R9 R10", "rf_we", DW'(rf_we), DW'(e_we));
        if (e_we) begin
            chk("R2 R9", "rf_waddr", DW'(rf_waddr), DW'(mw ? m_rd : wb_rd));
            chk("R2 R9", "rf_wdata", rf_wdata, mw ? m_prod : wb_data);
        end
        chk("R9", "wb_hold", DW'(wb_hold), DW'(mw && wb_we));
        chk("R7 R8", "m_hold", DW'(m_hold), DW'(e_hold));
        chk("R3 R4 R5 R6 R10", "d_bubble", DW'(d_bubble), DW'(e_bub));
        if (flush || mdone) m_pend = 0;
        else if (m_pend) m_age++;
        if (iss) begin
            m_pend = 1; m_age = 1; m_rd = ex_mul_rd; m_mode = ovf_exc_en;
            m_prod = ex_mul_a * ex_mul_b;
        end
        @(negedge clk);
    endtask

    task automatic issue(input logic [AW-1:0] rd, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input logic ovf);
        ex_mul_issue = 1; ex_mul_rd = rd; ex_mul_a = a; ex_mul_b = b;
        ovf_exc_en = ovf;
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        m_pend = 0; m_age = 0; m_rd = 0; m_mode = 0; m_prod = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R1: reset state with idle inputs.
        chk("R1", "d_bubble", DW'(d_bubble), 0);
        chk("R1", "m_hold",   DW'(m_hold),   0);
        chk("R1", "wb_hold",  DW'(wb_hold),  0);
        chk("R1", "rf_we",    DW'(rf_we),    0);
        @(negedge clk);

        // R2 R3: pass-mode multiply, dependent in decode until written.
        issue(5, 7, 9, 0); dec_valid = 1; dec_rs1 = 5;
        run_cycle();
        ex_mul_issue = 0;
        repeat (LAT + 1) run_cycle();
        idle(); run_cycle();

        // R8 R9 R4 R6: hold mode, mode latched, collision in write cycle.
        issue(3, 32'h1234, 32'h10, 1);
        run_cycle();
        idle(); ovf_exc_en = 0; dec_valid = 1; dec_we = 1; dec_rd = 3;
        run_cycle();
        dec_is_mul = 1;
        run_cycle(); run_cycle();
        wb_we = 1; wb_rd = 7; wb_data = 32'hdead;
        run_cycle();
        run_cycle();
        idle(); run_cycle();

        // R5: multiply to register 0.
        issue(0, 3, 3, 0); dec_valid = 1; dec_rs1 = 0; dec_we = 1; dec_rd = 0;
        run_cycle();
        ex_mul_issue = 0;
        repeat (LAT) run_cycle();
        idle(); run_cycle();

        // R10: flush after issue, and flush together with issue.
        issue(9, 5, 6, 1); run_cycle();
        idle(); flush = 1; dec_valid = 1; dec_rs2 = 9; run_cycle();
        flush = 0; repeat (LAT + 1) run_cycle();
        issue(10, 2, 2, 0); flush = 1; run_cycle();
        idle(); dec_valid = 1; dec_rs1 = 10; repeat (LAT + 1) run_cycle();

        // Constrained random traffic.
        void'($urandom(32'h5eed));
        for (int i = 0; i < 3000; i++) begin
            idle();
            ovf_exc_en = 1'($urandom());
            flush      = ($urandom() % 16) == 0;
            if (!m_pend && ($urandom() % 3) == 0)
                issue(AW'($urandom() % 8), $urandom(), $urandom(), ovf_exc_en);
            dec_valid  = 1'($urandom());
            dec_rs1    = AW'($urandom() % 8);
            dec_rs2    = AW'($urandom() % 8);
            dec_we     = 1'($urandom());
            dec_rd     = AW'($urandom() % 8);
            dec_is_mul = ($urandom() % 4) == 0;
            wb_we      = 1'($urandom());
            wb_rd      = AW'($urandom());
            wb_data    = $urandom();
            run_cycle();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule